// File: doc/BRIEF.md
# General-Purpose IO Bank Controller

This block manages one bank of general-purpose pins (32 by default) from a small register bus with separate write and read strobes, a word address and a data word. Every pin can be owned either by this controller or by one of two on-chip peripherals. Ownership, output drive, output level, pull-up, peripheral choice and interrupt masking are each held as one bit per pin. Software changes them only through register pairs: one register sets bits and the other clears them, and a data bit of 0 leaves its pin untouched. Several software agents can therefore change disjoint pins without a read-modify-write sequence.

Pad inputs pass through a synchronizer. The synchronized levels can be read back at any time, whatever the pin's owner. Any rising or falling edge of a synchronized input is held in a change-status register. A single level interrupt is raised while a held change meets a set mask bit. Reading the change-status register returns the held bits and clears them.

Word map (address = word index): 0 own-set, 1 own-clear, 2 own-status, 3 drive-enable, 4 drive-disable, 5 drive-status, 6 level-set, 7 level-clear, 8 level-status, 9 pad-status, 10 pull-enable, 11 pull-disable, 12 pull-status, 13 select-A, 14 select-B, 15 select-status, 16 irq-enable, 17 irq-disable, 18 irq-mask, 19 change-status.

Top module: `pio_bank`

## Requirements
- R1: After reset every pin is owned by the controller (own-status all 1), drive is off (pad_oe all 0), pull-ups are on (pad_pu all 1), peripheral A is chosen (select-status all 0), the irq mask is 0, the change-status is 0, the level latch is 0 and irq is low.
- R2: A write to own-set (word 0) gives each pin written as 1 to the controller. A write to own-clear (word 1) gives each such pin to its peripheral. Pins written as 0 keep their owner. Word 2 reads 1 for each controller-owned pin.
- R3: Drive-enable (word 3) and drive-disable (word 4) set and clear the per-pin drive bits, with write-1 semantics, readable at word 5. A controller-owned pin has pad_oe equal to its drive bit.
- R4: Level-set (word 6) drives 1 and level-clear (word 7) drives 0 on each pin written as 1, readable at word 8. A controller-owned pin has pad_out equal to its level bit.
- R5: Pad-status (word 9) returns the pad_in level seen two clock edges before the read edge, for every pin, whatever its owner.
- R6: Pull-enable (word 10) and pull-disable (word 11) set and clear pad_pu bits, with write-1 semantics, readable at word 12.
- R7: A peripheral-owned pin takes pad_out and pad_oe from peripheral A when its select bit is 0, and from peripheral B when it is 1. Select-A (word 13) clears and select-B (word 14) sets that bit, readable at word 15.
- R8: Irq-enable (word 16) and irq-disable (word 17) set and clear mask bits, readable at word 18. Writing all ones to word 17 clears the whole mask.
- R9: Each rising or falling edge of a synchronized input sets its change-status bit (word 19) one edge after the synchronized level changes, that is, on the third clock edge after pad_in changes. The bit stays set until it is cleared by a read.
- R10: irq is high exactly while some pin has both its change-status bit and its mask bit set.
- R11: A read of word 19 returns the held change bits and clears them on the same edge. A change latched on that same edge stays set.
- R12: Read data is registered. It shows the addressed word from the clock edge on which rd_en is sampled and holds until the next read. Unmapped or write-only words read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W (5) | Word address |
| wdata | input | DW (32) | Write data, one bit per pin |
| rdata | output | DW (32) | Registered read data |
| pad_in | input | NPIN (32) | Pad input levels |
| pad_out | output | NPIN (32) | Pad output levels |
| pad_oe | output | NPIN (32) | Pad output enables |
| pad_pu | output | NPIN (32) | Pad pull-up enables |
| pera_out | input | NPIN (32) | Peripheral A output levels |
| pera_oe | input | NPIN (32) | Peripheral A output enables |
| perb_out | input | NPIN (32) | Peripheral B output levels |
| perb_oe | input | NPIN (32) | Peripheral B output enables |
| irq | output | 1 | Level interrupt |

## Verification
The assertions assume that wr_en and rd_en are never high in the same cycle. They also assume that a set register and its clear register are never written on one edge, and the one-address bus makes that second case impossible. The bench issues strictly one bus operation per cycle. It holds pad_in at 0 through reset, so the synchronizer starts in step with the pads. It also times pad toggles so that some change events land exactly on a change-status read edge, which exercises the case where a clear and a new latch meet.

// File: rtl/pio_bank_pkg.sv
package pio_bank_pkg;

   typedef enum logic [4:0] {
      RG_OWN_SET   = 5'd0,
      RG_OWN_CLR   = 5'd1,
      RG_OWN_STAT  = 5'd2,
      RG_DRV_EN    = 5'd3,
      RG_DRV_DIS   = 5'd4,
      RG_DRV_STAT  = 5'd5,
      RG_LVL_SET   = 5'd6,
      RG_LVL_CLR   = 5'd7,
      RG_LVL_STAT  = 5'd8,
      RG_PAD_STAT  = 5'd9,
      RG_PU_EN     = 5'd10,
      RG_PU_DIS    = 5'd11,
      RG_PU_STAT   = 5'd12,
      RG_SEL_A     = 5'd13,
      RG_SEL_B     = 5'd14,
      RG_SEL_STAT  = 5'd15,
      RG_IRQ_EN    = 5'd16,
      RG_IRQ_DIS   = 5'd17,
      RG_IRQ_MASK  = 5'd18,
      RG_CHG_STAT  = 5'd19
   } pio_reg_e;

   localparam int unsigned REG_IDX_W = 5;

endpackage

// File: rtl/pio_setclr_reg.sv
module pio_setclr_reg #(
   parameter int unsigned W = 32,
   parameter bit          RST_VAL = 1'b0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] wmask,
   output logic [W-1:0] q
);

   generate
      if (W < 1) begin : g_bad_w
         $error("pio_setclr_reg: W must be at least 1");
      end
   endgenerate

   localparam logic [W-1:0] RST_WORD = {W{RST_VAL}};

   always_ff @(posedge clk) begin
      if (rst) begin
         q <= RST_WORD;
      end else if (set_en) begin
         q <= q | wmask;
      end else if (clr_en) begin
         q <= q & ~wmask;
      end
   end

   // R2: written ones take effect, zeros leave bits alone
   p_set_bits_r2: assert property (@(posedge clk) disable iff (rst)
      (set_en && !clr_en) |=> ((q & $past(wmask)) == $past(wmask)));
   p_clr_bits_r2: assert property (@(posedge clk) disable iff (rst)
      (clr_en && !set_en) |=> ((q & $past(wmask)) == '0));
   p_keep_unwritten_r2: assert property (@(posedge clk) disable iff (rst)
      (set_en || clr_en) |=> ((q & ~$past(wmask)) == ($past(q) & ~$past(wmask))));
   p_idle_stable_r2: assert property (@(posedge clk) disable iff (rst)
      (!set_en && !clr_en) |=> $stable(q));

endmodule

// File: rtl/pio_in_sync.sv
module pio_in_sync #(
   parameter int unsigned W      = 32,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("pio_in_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [W-1:0] stg [STAGES];

   always_ff @(posedge clk) begin
      if (rst) begin
         for (int k = 0; k < int'(STAGES); k++) stg[k] <= '0;
      end else begin
         stg[0] <= d;
         for (int k = 1; k < int'(STAGES); k++) stg[k] <= stg[k-1];
      end
   end

   assign q = stg[STAGES-1];

endmodule

// File: rtl/pio_chg_irq.sv
module pio_chg_irq #(
   parameter int unsigned W = 32
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] mask,
   input  logic         rd_clr,
   output logic [W-1:0] stat,
   output logic         irq
);

   logic [W-1:0] lvl_prev;
   logic [W-1:0] chg_evt;
   logic [W-1:0] keep;

   assign chg_evt = lvl ^ lvl_prev;
   assign keep    = rd_clr ? '0 : stat;

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_prev <= '0;
         stat     <= '0;
      end else begin
         lvl_prev <= lvl;
         stat     <= keep | chg_evt;
      end
   end

   assign irq = |(stat & mask);

   // R9: an edge is always captured
   p_edge_latched_r9: assert property (@(posedge clk) disable iff (rst)
      (chg_evt != '0) |=> ((stat & $past(chg_evt)) == $past(chg_evt)));
   // R9: held bits survive unless read
   p_sticky_r9: assert property (@(posedge clk) disable iff (rst)
      !rd_clr |=> ((stat & $past(stat)) == $past(stat)));
   // R11: read with no new edge leaves status empty
   p_clear_on_read_r11: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && chg_evt == '0) |=> (stat == '0));
   // R10: no interrupt without a mask bit
   p_irq_needs_mask_r10: assert property (@(posedge clk) disable iff (rst)
      irq |-> (mask != '0));

endmodule

// File: rtl/pio_pin_mux.sv
module pio_pin_mux #(
   parameter int unsigned W = 32
) (
   input  logic [W-1:0] own_pio,
   input  logic [W-1:0] sel_b,
   input  logic [W-1:0] lvl,
   input  logic [W-1:0] drv,
   input  logic [W-1:0] pa_out,
   input  logic [W-1:0] pa_oe,
   input  logic [W-1:0] pb_out,
   input  logic [W-1:0] pb_oe,
   output logic [W-1:0] pad_out,
   output logic [W-1:0] pad_oe
);

   generate
      for (genvar i = 0; i < int'(W); i++) begin : g_pin
         logic per_out;
         logic per_oe;
         assign per_out    = sel_b[i] ? pb_out[i] : pa_out[i];
         assign per_oe     = sel_b[i] ? pb_oe[i]  : pa_oe[i];
         assign pad_out[i] = own_pio[i] ? lvl[i] : per_out;
         assign pad_oe[i]  = own_pio[i] ? drv[i] : per_oe;
      end
   endgenerate

endmodule

// File: rtl/pio_bank.sv
module pio_bank
   import pio_bank_pkg::*;
#(
   parameter int unsigned NPIN        = 32,
   parameter int unsigned DW          = 32,
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              wr_en,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DW-1:0]     wdata,
   output logic [DW-1:0]     rdata,
   input  logic [NPIN-1:0]   pad_in,
   output logic [NPIN-1:0]   pad_out,
   output logic [NPIN-1:0]   pad_oe,
   output logic [NPIN-1:0]   pad_pu,
   input  logic [NPIN-1:0]   pera_out,
   input  logic [NPIN-1:0]   pera_oe,
   input  logic [NPIN-1:0]   perb_out,
   input  logic [NPIN-1:0]   perb_oe,
   output logic              irq
);

   generate
      if (NPIN < 1 || NPIN > DW) begin : g_bad_npin
         $error("pio_bank: NPIN must be in 1..DW");
      end
      if (ADDR_W < REG_IDX_W) begin : g_bad_aw
         $error("pio_bank: ADDR_W too small for the register map");
      end
   endgenerate

   localparam logic [NPIN-1:0] ALL_ONES = {NPIN{1'b1}};

   logic [NPIN-1:0] wmask;
   logic [REG_IDX_W-1:0] ridx;
   logic            addr_hi_zero;
   assign wmask = wdata[NPIN-1:0];
   assign ridx  = addr[REG_IDX_W-1:0];

   generate
      if (ADDR_W > REG_IDX_W) begin : g_hi
         assign addr_hi_zero = (addr[ADDR_W-1:REG_IDX_W] == '0);
      end else begin : g_nohi
         assign addr_hi_zero = 1'b1;
      end
   endgenerate

   function automatic logic hit(input logic en, input logic ok,
                                input logic [REG_IDX_W-1:0] a, input pio_reg_e r);
      return en && ok && (a == r);
   endfunction

   logic [NPIN-1:0] own_q, drv_q, lvl_q, pu_q, selb_q, msk_q;
   logic [NPIN-1:0] pad_sync, chg_stat;
   logic            chg_rd;

   pio_setclr_reg #(.W(NPIN), .RST_VAL(1'b1)) u_own (
      .clk(clk), .rst(rst),
      .set_en(hit(wr_en, addr_hi_zero, ridx, RG_OWN_SET)),
      .clr_en(hit(wr_en, addr_hi_zero, ridx, RG_OWN_CLR)),
      .wmask(wmask), .q(own_q));

   pio_setclr_reg #(.W(NPIN), .RST_VAL(1'b0)) u_drv (
      .clk(clk), .rst(rst),
      .set_en(hit(wr_en, addr_hi_zero, ridx, RG_DRV_EN)),
      .clr_en(hit(wr_en, addr_hi_zero, ridx, RG_DRV_DIS)),
      .wmask(wmask), .q(drv_q));

   pio_setclr_reg #(.W(NPIN), .RST_VAL(1'b0)) u_lvl (
      .clk(clk), .rst(rst),
      .set_en(hit(wr_en, addr_hi_zero, ridx, RG_LVL_SET)),
      .clr_en(hit(wr_en, addr_hi_zero, ridx, RG_LVL_CLR)),
      .wmask(wmask), .q(lvl_q));

   pio_setclr_reg #(.W(NPIN), .RST_VAL(1'b1)) u_pu (
      .clk(clk), .rst(rst),
      .set_en(hit(wr_en, addr_hi_zero, ridx, RG_PU_EN)),
      .clr_en(hit(wr_en, addr_hi_zero, ridx, RG_PU_DIS)),
      .wmask(wmask), .q(pu_q));

   pio_setclr_reg #(.W(NPIN), .RST_VAL(1'b0)) u_sel (
      .clk(clk), .rst(rst),
      .set_en(hit(wr_en, addr_hi_zero, ridx, RG_SEL_B)),
      .clr_en(hit(wr_en, addr_hi_zero, ridx, RG_SEL_A)),
      .wmask(wmask), .q(selb_q));

   pio_setclr_reg #(.W(NPIN), .RST_VAL(1'b0)) u_msk (
      .clk(clk), .rst(rst),
      .set_en(hit(wr_en, addr_hi_zero, ridx, RG_IRQ_EN)),
      .clr_en(hit(wr_en, addr_hi_zero, ridx, RG_IRQ_DIS)),
      .wmask(wmask), .q(msk_q));

   pio_in_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst(rst), .d(pad_in), .q(pad_sync));

   assign chg_rd = hit(rd_en, addr_hi_zero, ridx, RG_CHG_STAT);

   pio_chg_irq #(.W(NPIN)) u_chg (
      .clk(clk), .rst(rst), .lvl(pad_sync), .mask(msk_q),
      .rd_clr(chg_rd), .stat(chg_stat), .irq(irq));

   pio_pin_mux #(.W(NPIN)) u_mux (
      .own_pio(own_q), .sel_b(selb_q), .lvl(lvl_q), .drv(drv_q),
      .pa_out(pera_out), .pa_oe(pera_oe), .pb_out(perb_out), .pb_oe(perb_oe),
      .pad_out(pad_out), .pad_oe(pad_oe));

   assign pad_pu = pu_q;

   logic [NPIN-1:0] rd_word;

   always_comb begin
      rd_word = '0;
      if (addr_hi_zero) begin
         case (ridx)
            RG_OWN_STAT: rd_word = own_q;
            RG_DRV_STAT: rd_word = drv_q;
            RG_LVL_STAT: rd_word = lvl_q;
            RG_PAD_STAT: rd_word = pad_sync;
            RG_PU_STAT:  rd_word = pu_q;
            RG_SEL_STAT: rd_word = selb_q;
            RG_IRQ_MASK: rd_word = msk_q;
            RG_CHG_STAT: rd_word = chg_stat;
            default:     rd_word = '0;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         rdata <= '0;
      end else if (rd_en) begin
         rdata <= DW'(rd_word);
      end
   end

   // R12: read data holds between reads
   p_rd_hold_r12: assert property (@(posedge clk) disable iff (rst)
      !rd_en |=> $stable(rdata));
   // R8: disable-all wipes the mask
   p_disable_all_r8: assert property (@(posedge clk) disable iff (rst)
      (hit(wr_en, addr_hi_zero, ridx, RG_IRQ_DIS) && wmask == ALL_ONES) |=> (msk_q == '0));
   // R11: a read of the change word clears what it returned
   p_read_returns_r11: assert property (@(posedge clk) disable iff (rst)
      chg_rd |=> ((chg_stat & rdata[NPIN-1:0]) == '0 || $past(pad_sync ^ $past(pad_sync)) != '0));
   // R3: controller-owned driven pin enables its pad
   p_pio_oe_r3: assert property (@(posedge clk) disable iff (rst)
      ((own_q & drv_q) != '0) |-> ((pad_oe & own_q & drv_q) == (own_q & drv_q)));

endmodule

// File: tb/pio_bank_tb_top.sv
module pio_bank_tb_top;

   localparam int NP = 32;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic          wr_en = 1'b0;
   logic          rd_en = 1'b0;
   logic [4:0]    addr = '0;
   logic [31:0]   wdata = '0;
   logic [31:0]   rdata;
   logic [NP-1:0] pad_in = '0;
   logic [NP-1:0] pad_out, pad_oe, pad_pu;
   logic [NP-1:0] pera_out = '0, pera_oe = '0, perb_out = '0, perb_oe = '0;
   logic          irq;

   always #2 clk = ~clk;

   pio_bank dut_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out),
      .pad_oe(pad_oe), .pad_pu(pad_pu), .pera_out(pera_out), .pera_oe(pera_oe),
      .perb_out(perb_out), .perb_oe(perb_oe), .irq(irq));

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // reference model state
   logic [NP-1:0] m_own, m_drv, m_lvl, m_pu, m_selb, m_msk, m_chg;
   logic [NP-1:0] m_s1, m_s2, m_prev;
   logic [31:0]   exp_rd_q[$];
   bit            started = 0;

   function automatic logic [31:0] m_read(input logic [4:0] a);
      case (a)
         5'd2:  return m_own;
         5'd5:  return m_drv;
         5'd8:  return m_lvl;
         5'd9:  return m_s2;
         5'd12: return m_pu;
         5'd15: return m_selb;
         5'd18: return m_msk;
         5'd19: return m_chg;
         default: return 32'd0;
      endcase
   endfunction

   always @(posedge clk) begin
      started = 1;
      if (rst) begin
         m_own = '1; m_drv = '0; m_lvl = '0; m_pu = '1; m_selb = '0;
         m_msk = '0; m_chg = '0; m_s1 = '0; m_s2 = '0; m_prev = '0;
         exp_rd_q.delete();
         exp_rd_q.push_back(32'd0);
      end else begin
         logic [NP-1:0] edges;
         edges = m_s2 ^ m_prev;
         if (rd_en) begin
            exp_rd_q.push_back(m_read(addr));
            if (addr == 5'd19) m_chg = '0;
         end
         m_chg = m_chg | edges;
         if (wr_en) begin
            case (addr)
               5'd0:  m_own  = m_own | wdata;
               5'd1:  m_own  = m_own & ~wdata;
               5'd3:  m_drv  = m_drv | wdata;
               5'd4:  m_drv  = m_drv & ~wdata;
               5'd6:  m_lvl  = m_lvl | wdata;
               5'd7:  m_lvl  = m_lvl & ~wdata;
               5'd10: m_pu   = m_pu | wdata;
               5'd11: m_pu   = m_pu & ~wdata;
               5'd13: m_selb = m_selb & ~wdata;
               5'd14: m_selb = m_selb | wdata;
               5'd16: m_msk  = m_msk | wdata;
               5'd17: m_msk  = m_msk & ~wdata;
               default: ;
            endcase
         end
         m_prev = m_s2;
         m_s2   = m_s1;
         m_s1   = pad_in;
      end
   end

   logic [31:0] last_rd = 32'd0;

   // compare on every falling edge
   always @(negedge clk) begin
      if (started) begin
         logic [NP-1:0] e_out, e_oe;
         for (int i = 0; i < NP; i++) begin
            e_out[i] = m_own[i] ? m_lvl[i] : (m_selb[i] ? perb_out[i] : pera_out[i]);
            e_oe[i]  = m_own[i] ? m_drv[i] : (m_selb[i] ? perb_oe[i]  : pera_oe[i]);
         end
         chk("R4 R7 pad_out", pad_out, e_out);
         chk("R3 R7 pad_oe", pad_oe, e_oe);
         chk("R6 pad_pu", pad_pu, m_pu);
         chk("R10 irq", {31'd0, irq}, {31'd0, |(m_chg & m_msk)});
         while (exp_rd_q.size() > 0) last_rd = exp_rd_q.pop_front();
         chk("R12 rdata", rdata, last_rd);
      end
   end

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; wdata = '0;
   endtask

   task automatic rd(input logic [4:0] a);
      rd_en = 1'b1; addr = a;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      repeat (4) @(negedge clk);
      rst = 1'b0;
      // R1: reset state readback
      rd(5'd2); chk("R1 own after reset", rdata, 32'hFFFF_FFFF);
      rd(5'd5); chk("R1 drive after reset", rdata, 32'h0);
      rd(5'd12); chk("R1 pull after reset", rdata, 32'hFFFF_FFFF);
      rd(5'd15); chk("R1 select after reset", rdata, 32'h0);
      rd(5'd18); chk("R1 mask after reset", rdata, 32'h0);
      rd(5'd19); chk("R1 change after reset", rdata, 32'h0);
      chk("R1 irq after reset", {31'd0, irq}, 32'd0);
      // R3 R4: drive and levels
      wr(5'd3, 32'h0000_FFFF);
      wr(5'd6, 32'hA5A5_A5A5);
      wr(5'd7, 32'h0000_0005);
      rd(5'd8); chk("R4 level latch", rdata, 32'hA5A5_A5A0);
      chk("R4 pad_out", pad_out, 32'hA5A5_A5A0);
      wr(5'd4, 32'h0000_00F0);
      rd(5'd5); chk("R3 drive status", rdata, 32'h0000_FF0F);
      // R6
      wr(5'd11, 32'h00FF_0000);
      wr(5'd10, 32'h0001_0000);
      rd(5'd12); chk("R6 pull status", rdata, 32'hFF01_FFFF);
      // R2 R7: peripheral ownership
      pera_out = 32'h1234_5678; pera_oe = 32'hFFFF_0000;
      perb_out = 32'h8765_4321; perb_oe = 32'h0000_FFFF;
      wr(5'd1, 32'hFF00_FF00);
      wr(5'd14, 32'h0F00_0F00);
      wr(5'd0, 32'h0000_0000);
      rd(5'd2); chk("R2 own zero write ignored", rdata, 32'h00FF_00FF);
      rd(5'd15); chk("R7 select status", rdata, 32'h0F00_0F00);
      wr(5'd13, 32'h0100_0000);
      rd(5'd15); chk("R7 select A write", rdata, 32'h0E00_0F00);
      wr(5'd0, 32'h0000_0F00);
      rd(5'd2); chk("R2 own set", rdata, 32'h00FF_0FFF);
      // R5: pad status regardless of owner
      pad_in = 32'hC3C3_3C3C;
      idle(3);
      rd(5'd9); chk("R5 pad status", rdata, 32'hC3C3_3C3C);
      // R8 R9 R10 R11
      rd(5'd19); chk("R9 change bits", rdata, 32'hC3C3_3C3C);
      rd(5'd19); chk("R11 cleared by read", rdata, 32'h0);
      wr(5'd16, 32'hFFFF_0000);
      rd(5'd18); chk("R8 mask status", rdata, 32'hFFFF_0000);
      pad_in = pad_in ^ 32'h0000_0010;
      idle(4);
      chk("R10 unmasked change no irq", {31'd0, irq}, 32'd0);
      pad_in = pad_in ^ 32'h0001_0000;
      idle(2);
      chk("R9 not yet latched", {31'd0, irq}, 32'd0);
      idle(1);
      chk("R9 R10 irq after third edge", {31'd0, irq}, 32'd1);
      rd(5'd19); chk("R11 read returns", rdata, 32'h0001_0010);
      chk("R10 irq drops after read", {31'd0, irq}, 32'd0);
      // R11: change arriving on the read edge, at several offsets
      for (int off = 0; off < 5; off++) begin
         pad_in = pad_in ^ 32'h0002_0000;
         idle(off);
         rd(5'd19);
         idle(4);
         rd(5'd19);
      end
      wr(5'd17, 32'hFFFF_FFFF);
      rd(5'd18); chk("R8 disable all", rdata, 32'h0);
      rd(5'd31); chk("R12 unmapped reads zero", rdata, 32'h0);
      rd(5'd0); chk("R12 write-only reads zero", rdata, 32'h0);
      // mixed random traffic, checked against the model each cycle
      for (int n = 0; n < 2000; n++) begin
         int op;
         op = $urandom_range(0, 9);
         if (op < 2) pad_in = pad_in ^ (32'h1 << $urandom_range(0, 31));
         if (op == 2) begin
            pera_out = $urandom; pera_oe = $urandom;
            perb_out = $urandom; perb_oe = $urandom;
         end
         if (op >= 3 && op <= 5) wr(5'($urandom_range(0, 19)), $urandom);
         else if (op >= 6 && op <= 8) rd(5'($urandom_range(0, 21)));
         else idle(1);
      end
      idle(3);
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
   end

endmodule